// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Controller

This block turns device-side interrupt requests into address/data write messages for a function with `NUM_VEC` interrupt vectors. Each vector owns a table entry holding a 64-bit message address, a 32-bit message data word and a mask bit. A pending bit array records requests that arrive while a vector is masked. Two function-level control bits gate all vectors: an enable and a mask-all. A use counter per vector decides whether requests to that vector are accepted at all.

Software reaches the table and the pending array through a 32-bit register port. Reads return one cycle after the request. Accepted requests to unmasked vectors, and pending requests released by an unmask, leave on a valid/ready message port. Only one message is outstanding at a time. The port applies back-pressure by holding `msg_valid` with address, data and vector stable until `msg_ready` is seen. While one message waits, other deliverable vectors stay queued inside the block, and they are released lowest index first.

Top module: `vmsg_ctrl`

## Requirements
- R1: After reset, enable and mask-all are 0 and no message is valid. Every table address and data word reads 0. Every control word reads 1 (mask set), and the pending array reads 0.
- R2: Table register map, with v the vector: byte 16v+0 holds address bits 31:0, 16v+4 holds address bits 63:32, 16v+8 holds the data word, and 16v+12 is the control word. In the control word bit 0 is the mask, and the other bits read 0. Read data is valid with `reg_rvalid` one cycle after the request.
- R3: Pending bit of vector v is bit v mod 32 of pending word v/32, which equals bit v mod 8 of byte v/8, little-endian. Writes to the pending array are ignored.
- R4: A request is dropped, with no message and no pending bit, when its vector is ≥ NUM_VEC or when that vector's use count is zero.
- R5: A vector is masked when the function is disabled, when mask-all is set, or when its own mask bit is set. An accepted request to a masked vector sets its pending bit and issues no message.
- R6: An accepted request to an unmasked vector issues one message carrying that entry's address, data and vector index.
- R7: When a vector goes from masked to unmasked with its pending bit set, the pending bit clears and the message is issued. The unmask can come from a control-word write or a function control write.
- R8: Queued messages leave in ascending vector order, one at a time. Each holds valid, address, data and vector stable until ready.
- R9: `use_inc` increments and `use_dec` decrements the use count of `use_vec`. When the count returns to zero, that vector's pending bit clears. A decrement at zero has no effect.
- R10: A `ctrl_we` write loads enable from `ctrl_wdata[0]` and mask-all from `ctrl_wdata[1]`. `intx_inhibit` is high while enabled.
- R11: `tbl_size` reads NUM_VEC−1, and NUM_VEC must lie in 1..2048.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Function control write strobe |
| ctrl_wdata | input | 2 | Bit 0 enable, bit 1 mask-all |
| func_en | output | 1 | Current enable bit |
| func_maskall | output | 1 | Current mask-all bit |
| tbl_size | output | 11 | NUM_VEC−1 |
| intx_inhibit | output | 1 | High while the legacy line must stay deasserted |
| reg_req | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 1 | 0 = vector table, 1 = pending array |
| reg_addr | input | clog2(NUM_VEC)+4 | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rvalid | output | 1 | Read data valid |
| reg_rdata | output | 32 | Read data |
| irq_req | input | 1 | Interrupt request strobe |
| irq_vec | input | clog2(NUM_VEC)+1 | Requested vector |
| use_inc | input | 1 | Increment the use count |
| use_dec | input | 1 | Decrement the use count |
| use_vec | input | clog2(NUM_VEC)+1 | Vector for use_inc/use_dec |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Message accepted |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| msg_vec | output | clog2(NUM_VEC) | Vector index of the message |

## Verification
Some properties are checked on every cycle. The message port must hold steady under back-pressure, and at most one vector is dequeued per cycle. A vector is never pending and queued at the same time. No message leaves right after the function was disabled or fully masked, `intx_inhibit` follows the enable write, and a message vector is always within range. Other behaviour can only be shown by the bench scenarios: the contents of each message, the ascending release order after a function-wide unmask, dropped requests, pending-array readback with ignored writes, and use counts that cannot go below zero. A reference model checks these against random request, mask, control and use traffic under random back-pressure.

// File: rtl/vmsg_pkg.sv
package vmsg_pkg;
  localparam int MAX_VEC = 2048;

  typedef enum logic [1:0] {
    W_ADDR_LO = 2'd0,
    W_ADDR_HI = 2'd1,
    W_DATA    = 2'd2,
    W_CTRL    = 2'd3
  } vword_e;

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] data;
    logic        mask;
  } vent_t;
endpackage

// File: rtl/vmsg_slice.sv
module vmsg_slice
  import vmsg_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        func_mask,
  input  logic        wr_en,
  input  vword_e      wr_word,
  input  logic [31:0] wdata,
  input  logic        req,
  input  logic        inc,
  input  logic        dec,
  input  logic        taken,
  output vent_t       ent,
  output logic        pend,
  output logic        fire,
  output logic        eff,
  output logic        in_use
);
  logic [CNT_W-1:0] cnt;
  logic pend_n, fire_n;

  assign eff    = func_mask | ent.mask;
  assign in_use = (cnt != '0);

  // pending/queued state: mask moves queued to pending, unmask the reverse
  always_comb begin
    pend_n = pend;
    fire_n = fire & ~taken;
    if (pend_n && !eff) begin
      pend_n = 1'b0;
      fire_n = 1'b1;
    end
    if (fire_n && eff) begin
      fire_n = 1'b0;
      pend_n = 1'b1;
    end
    if (req && in_use) begin
      if (eff) pend_n = 1'b1;
      else     fire_n = 1'b1;
    end
    if (dec && !inc && cnt == CNT_W'(1)) begin
      pend_n = 1'b0;
      fire_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent  <= '{addr: '0, data: '0, mask: 1'b1};
      pend <= 1'b0;
      fire <= 1'b0;
      cnt  <= '0;
    end else begin
      pend <= pend_n;
      fire <= fire_n;
      if (inc && !dec && cnt != '1) cnt <= cnt + CNT_W'(1);
      else if (dec && !inc && cnt != '0) cnt <= cnt - CNT_W'(1);
      if (wr_en) begin
        case (wr_word)
          W_ADDR_LO: ent.addr[31:0]  <= wdata;
          W_ADDR_HI: ent.addr[63:32] <= wdata;
          W_DATA:    ent.data        <= wdata;
          default:   ent.mask        <= wdata[0];
        endcase
      end
    end
  end
endmodule

// File: rtl/vmsg_pick.sv
module vmsg_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  cand,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |cand;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/vmsg_ctrl.sv
module vmsg_ctrl
  import vmsg_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int CNT_W   = 4,
  localparam int VI_W   = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  localparam int VQ_W   = VI_W + 1,
  localparam int RA_W   = VI_W + 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctrl_we,
  input  logic [1:0]      ctrl_wdata,
  output logic            func_en,
  output logic            func_maskall,
  output logic [10:0]     tbl_size,
  output logic            intx_inhibit,
  input  logic            reg_req,
  input  logic            reg_we,
  input  logic            reg_sel,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic            reg_rvalid,
  output logic [31:0]     reg_rdata,
  input  logic            irq_req,
  input  logic [VQ_W-1:0] irq_vec,
  input  logic            use_inc,
  input  logic            use_dec,
  input  logic [VQ_W-1:0] use_vec,
  output logic            msg_valid,
  input  logic            msg_ready,
  output logic [63:0]     msg_addr,
  output logic [31:0]     msg_data,
  output logic [VI_W-1:0] msg_vec
);
  localparam int PW = (NUM_VEC + 31) / 32;
  localparam int PB = PW * 32;

  if (NUM_VEC < 1 || NUM_VEC > MAX_VEC) begin : g_bad_size
    $error("vmsg_ctrl: NUM_VEC out of range");
  end

  vent_t ent [NUM_VEC];
  logic [NUM_VEC-1:0] pend, fire, eff, inuse, taken;
  logic func_mask, tv_ok, pick_any, load_go;
  logic [VI_W-1:0] tv, pick_idx;
  logic [RA_W-3:0] widx;
  logic [PB-1:0] pend_pad;
  logic [31:0] rd_n;
  logic unused_addr_lsb;

  assign unused_addr_lsb = ^reg_addr[1:0];
  assign func_mask    = !func_en || func_maskall;
  assign intx_inhibit = func_en;
  assign tbl_size     = 11'(NUM_VEC - 1);
  assign tv           = reg_addr[RA_W-1:4];
  assign tv_ok        = ({1'b0, tv} < VQ_W'(NUM_VEC));
  assign widx         = reg_addr[RA_W-1:2];
  assign pend_pad     = PB'(pend);

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
    vmsg_slice #(.CNT_W(CNT_W)) u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .func_mask (func_mask),
      .wr_en     (reg_req && reg_we && !reg_sel && tv_ok && tv == VI_W'(i)),
      .wr_word   (vword_e'(reg_addr[3:2])),
      .wdata     (reg_wdata),
      .req       (irq_req && irq_vec == VQ_W'(i)),
      .inc       (use_inc && use_vec == VQ_W'(i)),
      .dec       (use_dec && use_vec == VQ_W'(i)),
      .taken     (taken[i]),
      .ent       (ent[i]),
      .pend      (pend[i]),
      .fire      (fire[i]),
      .eff       (eff[i]),
      .in_use    (inuse[i])
    );
  end

  vmsg_pick #(.N(NUM_VEC), .IW(VI_W)) u_pick (
    .cand (fire & ~eff),
    .any  (pick_any),
    .idx  (pick_idx)
  );

  assign load_go = pick_any && (!msg_valid || msg_ready);
  assign taken   = load_go ? (NUM_VEC'(1) << pick_idx) : '0;

  always_comb begin
    rd_n = '0;
    if (!reg_sel) begin
      if (tv_ok) begin
        case (vword_e'(reg_addr[3:2]))
          W_ADDR_LO: rd_n = ent[tv].addr[31:0];
          W_ADDR_HI: rd_n = ent[tv].addr[63:32];
          W_DATA:    rd_n = ent[tv].data;
          default:   rd_n = {31'd0, ent[tv].mask};
        endcase
      end
    end else begin
      for (int k = 0; k < PW; k++) begin
        if (widx == (RA_W-2)'(k)) rd_n = pend_pad[k*32 +: 32];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      func_en      <= 1'b0;
      func_maskall <= 1'b0;
      reg_rvalid   <= 1'b0;
      reg_rdata    <= '0;
      msg_valid    <= 1'b0;
      msg_addr     <= '0;
      msg_data     <= '0;
      msg_vec      <= '0;
    end else begin
      if (ctrl_we) begin
        func_en      <= ctrl_wdata[0];
        func_maskall <= ctrl_wdata[1];
      end
      reg_rvalid <= reg_req && !reg_we;
      if (reg_req && !reg_we) reg_rdata <= rd_n;
      if (!msg_valid || msg_ready) begin
        msg_valid <= pick_any;
        if (pick_any) begin
          msg_addr <= ent[pick_idx].addr;
          msg_data <= ent[pick_idx].data;
          msg_vec  <= pick_idx;
        end
      end
    end
  end
endmodule

// File: rtl/vmsg_ctrl_chk.sv
module vmsg_ctrl_chk #(
  parameter int NUM_VEC = 8,
  parameter int VI_W    = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               msg_valid,
  input logic               msg_ready,
  input logic [63:0]        msg_addr,
  input logic [31:0]        msg_data,
  input logic [VI_W-1:0]    msg_vec,
  input logic               func_en,
  input logic               func_maskall,
  input logic               ctrl_we,
  input logic [1:0]         ctrl_wdata,
  input logic               intx_inhibit,
  input logic [NUM_VEC-1:0] pend,
  input logic [NUM_VEC-1:0] fire,
  input logic [NUM_VEC-1:0] taken
);
  // R8
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data) && $stable(msg_vec));

  // R8
  one_dequeue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(taken));

  // R5
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(func_en && !func_maskall));

  // R7
  pend_fire_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & fire) == '0);

  // R10
  intx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> intx_inhibit == $past(ctrl_wdata[0]));

  // R6
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> {1'b0, msg_vec} < (VI_W+1)'(NUM_VEC));
endmodule

bind vmsg_ctrl vmsg_ctrl_chk #(.NUM_VEC(NUM_VEC), .VI_W(VI_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data), .msg_vec(msg_vec),
  .func_en(func_en), .func_maskall(func_maskall), .ctrl_we(ctrl_we),
  .ctrl_wdata(ctrl_wdata), .intx_inhibit(intx_inhibit),
  .pend(pend), .fire(fire), .taken(taken)
);

// File: tb/vmsg_ctrl_test.sv
module vmsg_ctrl_test;
  localparam int N = 8;
  localparam int VQ = 4;
  localparam int RA = 7;

  logic clk = 0, rst_n = 0;
  logic ctrl_we = 0; logic [1:0] ctrl_wdata = 0;
  logic func_en, func_maskall, intx_inhibit; logic [10:0] tbl_size;
  logic reg_req = 0, reg_we = 0, reg_sel = 0; logic [RA-1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0; logic reg_rvalid; logic [31:0] reg_rdata;
  logic irq_req = 0; logic [VQ-1:0] irq_vec = 0;
  logic use_inc = 0, use_dec = 0; logic [VQ-1:0] use_vec = 0;
  logic msg_valid, msg_ready = 1; logic [63:0] msg_addr; logic [31:0] msg_data; logic [2:0] msg_vec;

  vmsg_ctrl #(.NUM_VEC(N), .CNT_W(4)) uut (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit rnd_ready = 0;
  logic [63:0] m_addr [N]; logic [31:0] m_data [N];
  bit m_mask [N]; bit m_pend [N]; int m_use [N]; bit m_en, m_ma;
  int exp_q[$]; int got_v[$]; logic [63:0] got_a[$]; logic [31:0] got_d[$];

  always @(negedge clk)
    if (rst_n && msg_valid && msg_ready) begin
      got_v.push_back(int'(msg_vec)); got_a.push_back(msg_addr); got_d.push_back(msg_data);
    end

  initial forever begin
    @(posedge clk); #1;
    msg_ready = rnd_ready ? (($urandom % 3) != 0) : 1'b1;
  end

  task automatic check(bit ok, string rq, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic bit effm(int v);
    return !m_en || m_ma || m_mask[v];
  endfunction

  task automatic reg_wr(bit sel, int addr, logic [31:0] d);
    @(negedge clk); reg_req = 1; reg_we = 1; reg_sel = sel; reg_addr = RA'(addr); reg_wdata = d;
    @(negedge clk); reg_req = 0; reg_we = 0;
  endtask

  task automatic reg_rd(bit sel, int addr, output logic [31:0] d);
    @(negedge clk); reg_req = 1; reg_we = 0; reg_sel = sel; reg_addr = RA'(addr);
    @(negedge clk); reg_req = 0; d = reg_rdata;
    check(reg_rvalid === 1'b1, "R2", "rvalid", reg_rvalid, 1);
  endtask

  task automatic drain(string rq);
    repeat (60) @(negedge clk);
    check(got_v.size() == exp_q.size(), rq, "message count", got_v.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_v.size(); i++) begin
      int v = exp_q[i];
      check(got_v[i] == v && got_d[i] == m_data[v] && got_a[i] == m_addr[v],
            rq, "message vec/data", got_v[i], v);
    end
    exp_q.delete(); got_v.delete(); got_a.delete(); got_d.delete();
  endtask

  task automatic chk_pend(string rq);
    logic [31:0] d; logic [31:0] e = 0;
    reg_rd(1, 0, d);
    for (int v = 0; v < N; v++) e[v] = m_pend[v];
    check(d == e, rq, "pending word", d, e);
  endtask

  task automatic do_irq(int v);
    @(negedge clk); irq_req = 1; irq_vec = VQ'(v);
    @(negedge clk); irq_req = 0;
    if (v < N && m_use[v] > 0) begin
      if (effm(v)) m_pend[v] = 1; else exp_q.push_back(v);
    end
  endtask

  task automatic do_vmask(int v, bit m);
    bit old = effm(v);
    reg_wr(0, v * 16 + 12, {31'd0, m});
    m_mask[v] = m;
    if (old && !effm(v) && m_pend[v]) begin m_pend[v] = 0; exp_q.push_back(v); end
  endtask

  task automatic do_ctrl(bit en, bit ma);
    bit fm0 = !m_en || m_ma;
    @(negedge clk); ctrl_we = 1; ctrl_wdata = {ma, en};
    @(negedge clk); ctrl_we = 0;
    m_en = en; m_ma = ma;
    if (fm0 && !(!m_en || m_ma))
      for (int v = 0; v < N; v++)
        if (!m_mask[v] && m_pend[v]) begin m_pend[v] = 0; exp_q.push_back(v); end
  endtask

  task automatic do_use(int v, bit up);
    @(negedge clk); use_vec = VQ'(v); use_inc = up; use_dec = !up;
    @(negedge clk); use_inc = 0; use_dec = 0;
    if (up) m_use[v]++;
    else if (m_use[v] > 0) begin m_use[v]--; if (m_use[v] == 0) m_pend[v] = 0; end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int seed_init;
    seed_init = $urandom(32'h5eed);
    for (int v = 0; v < N; v++) begin
      m_addr[v] = 0; m_data[v] = 0; m_mask[v] = 1; m_pend[v] = 0; m_use[v] = 0;
    end
    m_en = 0; m_ma = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(func_en == 0 && func_maskall == 0, "R1", "control bits", {func_en, func_maskall}, 0);
    check(msg_valid == 0, "R1", "msg_valid", msg_valid, 0);
    reg_rd(0, 0 * 16 + 12, d); check(d == 1, "R1", "ctl v0", d, 1);
    reg_rd(0, 7 * 16 + 12, d); check(d == 1, "R1", "ctl v7", d, 1);
    reg_rd(0, 3 * 16 + 8, d);  check(d == 0, "R1", "data v3", d, 0);
    chk_pend("R1");
    // R11
    check(tbl_size == 11'(N - 1), "R11", "table size", tbl_size, N - 1);
    // R2 table programming and readback
    for (int v = 0; v < N; v++) begin
      m_addr[v] = {$urandom, $urandom}; m_data[v] = $urandom;
      reg_wr(0, v * 16 + 0, m_addr[v][31:0]);
      reg_wr(0, v * 16 + 4, m_addr[v][63:32]);
      reg_wr(0, v * 16 + 8, m_data[v]);
    end
    reg_rd(0, 5 * 16 + 0, d); check(d == m_addr[5][31:0], "R2", "addr lo v5", d, m_addr[5][31:0]);
    reg_rd(0, 5 * 16 + 4, d); check(d == m_addr[5][63:32], "R2", "addr hi v5", d, m_addr[5][63:32]);
    reg_rd(0, 5 * 16 + 8, d); check(d == m_data[5], "R2", "data v5", d, m_data[5]);
    reg_wr(0, 2 * 16 + 12, 32'hFFFF_FFFE); m_mask[2] = 0;
    reg_rd(0, 2 * 16 + 12, d); check(d == 0, "R2", "ctl upper bits", d, 0);
    // R3 pending writes ignored
    reg_wr(1, 0, 32'hFFFF_FFFF);
    chk_pend("R3");
    // setup: enable, unmask, use all except v6
    do_ctrl(1, 0);
    check(intx_inhibit == 1, "R10", "intx inhibit on", intx_inhibit, 1);
    for (int v = 0; v < N; v++) do_vmask(v, 0);
    for (int v = 0; v < N; v++) if (v != 6) do_use(v, 1);
    drain("R7");
    // R6
    do_irq(2); drain("R6");
    // R4
    do_irq(6); do_irq(9); do_irq(15); drain("R4"); chk_pend("R4");
    // R5 / R7 per-vector
    do_vmask(1, 1); do_irq(1); drain("R5"); chk_pend("R5");
    do_vmask(1, 0); drain("R7"); chk_pend("R7");
    // R5 / R8 function mask-all, ascending release
    do_ctrl(1, 1); do_irq(5); do_irq(3); do_irq(0); drain("R5"); chk_pend("R5");
    rnd_ready = 1;
    do_ctrl(1, 0); drain("R8"); chk_pend("R8");
    // R10 disable
    do_ctrl(0, 0);
    check(intx_inhibit == 0, "R10", "intx inhibit off", intx_inhibit, 0);
    do_irq(4); drain("R10"); chk_pend("R10");
    do_ctrl(1, 0); drain("R10");
    // R9 use counts
    do_use(4, 1); do_use(4, 1); do_vmask(4, 1); do_irq(4); chk_pend("R9");
    do_use(4, 0); do_use(4, 0); do_use(4, 0); chk_pend("R9");
    do_use(4, 0);
    do_vmask(4, 0); drain("R9");
    do_irq(4); drain("R9");
    do_use(4, 1); do_irq(4); drain("R9");
    // random phase
    for (int it = 0; it < 300; it++) begin
      int op = $urandom % 6;
      int v = $urandom % N;
      case (op)
        0, 1: do_irq($urandom % 10);
        2: do_vmask(v, $urandom % 2);
        3: do_ctrl(($urandom % 4) != 0, ($urandom % 3) == 0);
        4: if (m_use[v] < 14) do_use(v, 1);
        default: do_use(v, 0);
      endcase
      drain("R6");
      if (it % 10 == 0) chk_pend("R3");
    end
    finish_run();
  end
endmodule